// File: doc/BRIEF.md
# Converter Control Register Target on a Two-Wire Bus

This block is a two-wire serial bus target that answers at one fixed 7-bit address. It holds the control settings of a step-down converter: two voltage-select presets, each with its own enable bit, a discharge enable, the mode selection bits, the current-limit code, two output-range codes and a limit register. It drives these settings straight out as fields. It also shows a read-only live status byte, plus a byte of sticky event flags. Event inputs set the flags and the bus clears them.

The system clock oversamples both bus lines. Each line passes through a two-flop synchroniser and then a glitch filter, so no edge or START/STOP condition is acted upon until it has been stable for `FILT` clocks. A controller first writes a register index and then streams data bytes to consecutive indices. To read, it sets the index, issues a repeated START and reads bytes that again come from consecutive indices. The index survives a STOP, so a later read with no index write continues where the last access left off. SDA is only ever pulled low, through an open-drain enable. The registers live in the clocked logic alone, so they keep their values and stay accessible whether or not the converter itself is running.

Top module: `ctl_i2c_regs`

## Requirements
- R1: The block acknowledges only the address byte whose upper seven bits equal 7'b0011100. With any other address it never pulls SDA low, and the bytes that follow change nothing.
- R2: After reset: index 0x10 and 0x11 read 0x00; index 0x12 reads 0x10 (discharge enable bit 4 set); index 0x14 reads 0xC0 (mode bits 7:6 = 11); index 0x16 reads 0xC0 (current-limit code bits 7:6 = 11); index 0x1C reads 0x02; index 0x1D reads 0x01; index 0x1E reads 0xF0. The exported fields match these values.
- R3: A write transfer (address with R/W bit 0, index byte, data bytes) acknowledges every byte. The data bytes go to the index, the index plus one and so on, and each exported field updates before the acknowledge of its byte ends.
- R4: A combined read (write of the index, repeated START, address with R/W bit 1) returns bytes from the index upward. A master NACK ends the burst, after which the block leaves SDA released. The block changes SDA only while SCL is low.
- R5: Index 0x01 is read-only. Bit 7 shows the over-temperature input, bit 0 the power-good input, and bits 6:1 read 0. Writes to it change nothing.
- R6: Index 0x18 holds sticky flags: bit 7 is set by the over-current event, bit 4 by the short-circuit event and bit 1 by the input-undervoltage event. A set flag stays set until the bus writes 0 to that bit. Writing 1 leaves it unchanged.
- R7: Bits not listed in R2, R5 and R6 read as 0 and ignore writes. An index with no register (such as 0x13 or 0x40) reads 0x00 and ignores writes.
- R8: A low pulse on SDA or a high pulse on SCL that lasts fewer than `FILT` system clocks has no effect on a transfer in progress.
- R9: The register index is kept across a STOP. A read that starts without an index write returns bytes starting at the index left by the last access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low reset; applied at supply power-up |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain) |
| st_otemp | input | 1 | Live over-temperature status |
| st_pgood | input | 1 | Live power-good status |
| ev_ocp | input | 1 | Over-current event pulse |
| ev_scp | input | 1 | Short-circuit event pulse |
| ev_uvlo | input | 1 | Input-undervoltage event pulse |
| sel1_en | output | 1 | Enable for preset 1 (index 0x10 bit 7) |
| sel1_code | output | 7 | Voltage code for preset 1 (index 0x10 bits 6:0) |
| sel0_en | output | 1 | Enable for preset 0 (index 0x11 bit 7) |
| sel0_code | output | 7 | Voltage code for preset 0 (index 0x11 bits 6:0) |
| dischg_en | output | 1 | Output discharge enable (index 0x12 bit 4) |
| mode_sel | output | 2 | Mode bits (index 0x14 bits 7:6) |
| ilim_code | output | 2 | Current-limit code (index 0x16 bits 7:6) |
| bank1 | output | 2 | Output range code for preset 1 (index 0x1C bits 1:0) |
| bank0 | output | 2 | Output range code for preset 0 (index 0x1D bits 1:0) |
| vlim | output | 8 | Limit register (index 0x1E) |
| flags | output | 3 | Sticky flags {over-current, short-circuit, undervoltage} |

## Verification
Every exported field goes straight to the pins. A wrong bit in the register state therefore shows up on the clock where it is written, and the bench compares all 36 exported bits with its model on every clock outside a transfer. A wrong index or a bad transfer state shows up on the bus itself. It appears as a missing acknowledge within one bit time, or as wrong data at the first bit of the next byte read back. Sticky-flag and status faults stay invisible until the flags pin changes or index 0x01 or 0x18 is read, so the bench reads them back right after each event and after each clearing write.

// File: rtl/ctl_i2c_regs.sv
module ctl_i2c_regs #(
  parameter logic [6:0] DEV_ADDR = 7'b0011100,
  parameter int         FILT     = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic       st_otemp,
  input  logic       st_pgood,
  input  logic       ev_ocp,
  input  logic       ev_scp,
  input  logic       ev_uvlo,
  output logic       sel1_en,
  output logic [6:0] sel1_code,
  output logic       sel0_en,
  output logic [6:0] sel0_code,
  output logic       dischg_en,
  output logic [1:0] mode_sel,
  output logic [1:0] ilim_code,
  output logic [1:0] bank1,
  output logic [1:0] bank0,
  output logic [7:0] vlim,
  output logic [2:0] flags
);

  localparam int FW = $clog2(FILT + 1);
  localparam logic [FW-1:0] FLIM = FW'(FILT - 1);

  typedef enum logic [3:0] {
    S_IDLE, S_ADDR, S_AACK, S_REG, S_RACK, S_WR, S_WACK, S_TX, S_MACK
  } st_t;

  logic [1:0]    scl_s, sda_s;
  logic          scl_f, sda_f, scl_q, sda_q;
  logic [FW-1:0] scl_n, sda_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_s <= 2'b11;
      sda_s <= 2'b11;
      scl_f <= 1'b1;
      sda_f <= 1'b1;
      scl_q <= 1'b1;
      sda_q <= 1'b1;
      scl_n <= '0;
      sda_n <= '0;
    end else begin
      scl_s <= {scl_s[0], scl_i};
      sda_s <= {sda_s[0], sda_i};
      scl_q <= scl_f;
      sda_q <= sda_f;
      if (scl_s[1] == scl_f) scl_n <= '0;
      else if (scl_n == FLIM) begin
        scl_f <= scl_s[1];
        scl_n <= '0;
      end else scl_n <= scl_n + 1'b1;
      if (sda_s[1] == sda_f) sda_n <= '0;
      else if (sda_n == FLIM) begin
        sda_f <= sda_s[1];
        sda_n <= '0;
      end else sda_n <= sda_n + 1'b1;
    end
  end

  wire scl_rise = scl_f & ~scl_q;
  wire scl_fall = ~scl_f & scl_q;
  wire start_d  = scl_f & scl_q & sda_q & ~sda_f;
  wire stop_d   = scl_f & scl_q & ~sda_q & sda_f;

  st_t        st;
  logic [7:0] sh, ptr, wr_data, rdata;
  logic [3:0] cnt;
  logic       rw, nack, wr_stb;
  logic [7:0] r10, r11, r1e;
  logic       dis;
  logic [1:0] mode, ilim, b1, b0;

  wire rx_done = scl_fall && (cnt == 4'd8);

  always_comb begin
    case (ptr)
      8'h01:   rdata = {st_otemp, 6'b0, st_pgood};
      8'h10:   rdata = r10;
      8'h11:   rdata = r11;
      8'h12:   rdata = {3'b0, dis, 4'b0};
      8'h14:   rdata = {mode, 6'b0};
      8'h16:   rdata = {ilim, 6'b0};
      8'h18:   rdata = {flags[2], 2'b0, flags[1], 2'b0, flags[0], 1'b0};
      8'h1C:   rdata = {6'b0, b1};
      8'h1D:   rdata = {6'b0, b0};
      8'h1E:   rdata = r1e;
      default: rdata = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      sh      <= '0;
      ptr     <= '0;
      cnt     <= '0;
      rw      <= 1'b0;
      nack    <= 1'b0;
      sda_oe  <= 1'b0;
      wr_stb  <= 1'b0;
      wr_data <= '0;
    end else begin
      wr_stb <= 1'b0;
      if (wr_stb) ptr <= ptr + 8'd1;
      if (start_d) begin
        st     <= S_ADDR;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else if (stop_d) begin
        st     <= S_IDLE;
        sda_oe <= 1'b0;
      end else begin
        case (st)
          S_ADDR: begin
            if (scl_rise) begin
              sh  <= {sh[6:0], sda_f};
              cnt <= cnt + 4'd1;
            end else if (rx_done) begin
              cnt <= '0;
              if (sh[7:1] == DEV_ADDR) begin
                rw     <= sh[0];
                sda_oe <= 1'b1;
                st     <= S_AACK;
              end else st <= S_IDLE;
            end
          end
          S_REG: begin
            if (scl_rise) begin
              sh  <= {sh[6:0], sda_f};
              cnt <= cnt + 4'd1;
            end else if (rx_done) begin
              cnt    <= '0;
              ptr    <= sh;
              sda_oe <= 1'b1;
              st     <= S_RACK;
            end
          end
          S_WR: begin
            if (scl_rise) begin
              sh  <= {sh[6:0], sda_f};
              cnt <= cnt + 4'd1;
            end else if (rx_done) begin
              cnt     <= '0;
              wr_stb  <= 1'b1;
              wr_data <= sh;
              sda_oe  <= 1'b1;
              st      <= S_WACK;
            end
          end
          S_AACK: begin
            if (scl_fall) begin
              cnt <= '0;
              if (rw) begin
                sh     <= rdata;
                ptr    <= ptr + 8'd1;
                sda_oe <= ~rdata[7];
                st     <= S_TX;
              end else begin
                sda_oe <= 1'b0;
                st     <= S_REG;
              end
            end
          end
          S_RACK, S_WACK: begin
            if (scl_fall) begin
              sda_oe <= 1'b0;
              st     <= S_WR;
            end
          end
          S_TX: begin
            if (scl_fall) begin
              if (cnt == 4'd7) begin
                sda_oe <= 1'b0;
                st     <= S_MACK;
              end else begin
                sh     <= {sh[6:0], 1'b0};
                sda_oe <= ~sh[6];
                cnt    <= cnt + 4'd1;
              end
            end
          end
          S_MACK: begin
            if (scl_rise) nack <= sda_f;
            else if (scl_fall) begin
              cnt <= '0;
              if (nack) st <= S_IDLE;
              else begin
                sh     <= rdata;
                ptr    <= ptr + 8'd1;
                sda_oe <= ~rdata[7];
                st     <= S_TX;
              end
            end
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r10  <= 8'h00;
      r11  <= 8'h00;
      dis  <= 1'b1;
      mode <= 2'b11;
      ilim <= 2'b11;
      b1   <= 2'b10;
      b0   <= 2'b01;
      r1e  <= 8'hF0;
    end else if (wr_stb) begin
      case (ptr)
        8'h10: r10  <= wr_data;
        8'h11: r11  <= wr_data;
        8'h12: dis  <= wr_data[4];
        8'h14: mode <= wr_data[7:6];
        8'h16: ilim <= wr_data[7:6];
        8'h1C: b1   <= wr_data[1:0];
        8'h1D: b0   <= wr_data[1:0];
        8'h1E: r1e  <= wr_data;
        default: ;
      endcase
    end
  end

  wire clr_flags = wr_stb && (ptr == 8'h18);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= 3'b000;
    else flags <= (clr_flags ? (flags & {wr_data[7], wr_data[4], wr_data[1]}) : flags)
                  | {ev_ocp, ev_scp, ev_uvlo};
  end

  assign sel1_en   = r10[7];
  assign sel1_code = r10[6:0];
  assign sel0_en   = r11[7];
  assign sel0_code = r11[6:0];
  assign dischg_en = dis;
  assign mode_sel  = mode;
  assign ilim_code = ilim;
  assign bank1     = b1;
  assign bank0     = b0;
  assign vlim      = r1e;

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE) |-> !sda_oe);

  // R4
  sda_low_scl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> !scl_f);

  // R3
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> (ptr == $past(ptr) + 8'd1));

  // R6
  flag_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_flags |=> ((flags & $past(flags)) == $past(flags)));

  // R6
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_ocp && ev_scp && ev_uvlo) |=> (flags == 3'b111));

endmodule

// File: tb/ctl_i2c_regs_bench.sv
`timescale 1ns/1ps
module ctl_i2c_regs_bench;
  localparam int Q = 20;
  localparam logic [6:0] ADR = 7'b0011100;

  logic clk = 1'b0, rst_n = 1'b0;
  logic m_scl = 1'b1, m_low = 1'b0;
  logic st_otemp = 1'b0, st_pgood = 1'b0;
  logic ev_ocp = 1'b0, ev_scp = 1'b0, ev_uvlo = 1'b0;
  logic sda_oe;
  logic sel1_en, sel0_en, dischg_en;
  logic [6:0] sel1_code, sel0_code;
  logic [1:0] mode_sel, ilim_code, bank1, bank0;
  logic [7:0] vlim;
  logic [2:0] flags;
  wire sda_bus = ~(sda_oe | m_low);

  always #2.5 clk = ~clk;

  ctl_i2c_regs u_ctl_i2c_regs (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus), .sda_oe(sda_oe),
    .st_otemp(st_otemp), .st_pgood(st_pgood),
    .ev_ocp(ev_ocp), .ev_scp(ev_scp), .ev_uvlo(ev_uvlo),
    .sel1_en(sel1_en), .sel1_code(sel1_code), .sel0_en(sel0_en), .sel0_code(sel0_code),
    .dischg_en(dischg_en), .mode_sel(mode_sel), .ilim_code(ilim_code),
    .bank1(bank1), .bank0(bank0), .vlim(vlim), .flags(flags));

  int tests = 0, fails = 0;
  logic cmp_on = 1'b0;

  logic [7:0] m10 = 8'h00, m11 = 8'h00, m1e = 8'hF0;
  logic       mdis = 1'b1;
  logic [1:0] mmode = 2'b11, milim = 2'b11, mb1 = 2'b10, mb0 = 2'b01;
  logic [2:0] mflg = 3'b000;
  logic [7:0] rq [0:3];

  function automatic logic [7:0] mread(input logic [7:0] a);
    case (a)
      8'h01: return {st_otemp, 6'b0, st_pgood};
      8'h10: return m10;
      8'h11: return m11;
      8'h12: return mdis ? 8'h10 : 8'h00;
      8'h14: return {mmode, 6'b0};
      8'h16: return {milim, 6'b0};
      8'h18: return {mflg[2], 2'b0, mflg[1], 2'b0, mflg[0], 1'b0};
      8'h1C: return {6'b0, mb1};
      8'h1D: return {6'b0, mb0};
      8'h1E: return m1e;
      default: return 8'h00;
    endcase
  endfunction

  task automatic mwrite(input logic [7:0] a, input logic [7:0] d);
    case (a)
      8'h10: m10 = d;
      8'h11: m11 = d;
      8'h12: mdis = d[4];
      8'h14: mmode = d[7:6];
      8'h16: milim = d[7:6];
      8'h18: begin
        if (!d[7]) mflg[2] = 1'b0;
        if (!d[4]) mflg[1] = 1'b0;
        if (!d[1]) mflg[0] = 1'b0;
      end
      8'h1C: mb1 = d[1:0];
      8'h1D: mb0 = d[1:0];
      8'h1E: m1e = d;
      default: ;
    endcase
  endtask

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // every-clock comparison of exported fields against the model (R2, R3, R6, R7)
  always @(negedge clk) begin
    if (cmp_on && rst_n) begin
      tests++;
      if ({sel1_en, sel1_code, sel0_en, sel0_code, dischg_en, mode_sel, ilim_code, bank1, bank0, vlim, flags}
          !== {m10, m11, mdis, mmode, milim, mb1, mb0, m1e, mflg}) begin
        fails++;
        $display("FAIL R3/R6/R7 fields at %0t: actual %h expected %h", $time,
          {sel1_en, sel1_code, sel0_en, sel0_code, dischg_en, mode_sel, ilim_code, bank1, bank0, vlim, flags},
          {m10, m11, mdis, mmode, milim, mb1, mb0, m1e, mflg});
      end
    end
  end

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic i_start;
    m_low = 1'b0; wq(Q);
    m_scl = 1'b1; wq(2*Q);
    m_low = 1'b1; wq(Q);
    m_scl = 1'b0; wq(Q);
  endtask

  task automatic i_stop;
    m_low = 1'b1; wq(Q);
    m_scl = 1'b1; wq(Q);
    m_low = 1'b0; wq(2*Q);
  endtask

  task automatic bit_cycle(input logic b, output logic s);
    m_low = ~b; wq(Q);
    m_scl = 1'b1; wq(Q);
    s = sda_bus; wq(Q);
    m_scl = 1'b0; wq(Q);
  endtask

  task automatic send_byte(input logic [7:0] d, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) bit_cycle(d[i], s);
    bit_cycle(1'b1, s);
    ack = ~s;
  endtask

  task automatic recv_byte(input logic last, output logic [7:0] d);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      bit_cycle(1'b1, s);
      d[i] = s;
    end
    bit_cycle(last, s);
  endtask

  task automatic wr_run(input logic [7:0] a, input int n,
                        input logic [7:0] d0, input logic [7:0] d1, input logic [7:0] d2);
    logic ack;
    logic [7:0] dd [0:2];
    dd[0] = d0; dd[1] = d1; dd[2] = d2;
    cmp_on = 1'b0;
    i_start;
    send_byte({ADR, 1'b0}, ack); chk("R1 address ack", ack, 1'b1);
    send_byte(a, ack);           chk("R3 index ack", ack, 1'b1);
    for (int i = 0; i < n; i++) begin
      send_byte(dd[i], ack);     chk("R3 data ack", ack, 1'b1);
      mwrite(a + 8'(i), dd[i]);
    end
    i_stop;
    cmp_on = 1'b1;
  endtask

  task automatic rd_run(input logic [7:0] a, input int n);
    logic ack;
    i_start;
    send_byte({ADR, 1'b0}, ack); chk("R4 address ack", ack, 1'b1);
    send_byte(a, ack);           chk("R4 index ack", ack, 1'b1);
    i_start;
    send_byte({ADR, 1'b1}, ack); chk("R4 read address ack", ack, 1'b1);
    for (int i = 0; i < n; i++) recv_byte(i == n - 1, rq[i]);
    i_stop;
  endtask

  task automatic ev_pulse(input logic o, input logic s, input logic u);
    cmp_on = 1'b0;
    @(negedge clk); ev_ocp = o; ev_scp = s; ev_uvlo = u;
    @(negedge clk); ev_ocp = 1'b0; ev_scp = 1'b0; ev_uvlo = 1'b0;
    mflg = mflg | {o, s, u};
    cmp_on = 1'b1;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic ack;
    logic s;
    wq(10);
    rst_n = 1'b1;
    wq(2);
    // R2 reset state at the ports
    chk("R2 sel1", {sel1_en, sel1_code}, 8'h00);
    chk("R2 sel0", {sel0_en, sel0_code}, 8'h00);
    chk("R2 dischg", dischg_en, 1'b1);
    chk("R2 mode", mode_sel, 2'b11);
    chk("R2 ilim", ilim_code, 2'b11);
    chk("R2 banks", {bank1, bank0}, 4'b1001);
    chk("R2 vlim", vlim, 8'hF0);
    chk("R2 flags", flags, 3'b000);
    chk("R2 sda released", sda_oe, 1'b0);
    cmp_on = 1'b1;

    // R2 defaults over the bus
    rd_run(8'h1C, 3);
    chk("R2 read 0x1C", rq[0], 8'h02);
    chk("R2 read 0x1D", rq[1], 8'h01);
    chk("R2 read 0x1E", rq[2], 8'hF0);
    rd_run(8'h14, 3);
    chk("R2 read 0x14", rq[0], 8'hC0);
    chk("R7 read 0x15", rq[1], 8'h00);
    chk("R2 read 0x16", rq[2], 8'hC0);

    // R1 foreign address: no acknowledge, nothing written
    cmp_on = 1'b0;
    i_start;
    send_byte({7'b0011101, 1'b0}, ack); chk("R1 foreign address nack", ack, 1'b0);
    send_byte(8'h10, ack);              chk("R1 foreign index nack", ack, 1'b0);
    send_byte(8'hFF, ack);              chk("R1 foreign data nack", ack, 1'b0);
    i_stop;
    cmp_on = 1'b1;
    wq(4);
    chk("R1 sel1 untouched", {sel1_en, sel1_code}, 8'h00);

    // R3 bursts with auto-increment
    wr_run(8'h10, 2, 8'hA5, 8'h3C, 8'h00);
    wr_run(8'h1C, 3, 8'hFF, 8'hFE, 8'h5A);
    // R4 combined read back
    rd_run(8'h10, 2);
    chk("R4 read 0x10", rq[0], 8'hA5);
    chk("R4 read 0x11", rq[1], 8'h3C);
    rd_run(8'h1C, 3);
    chk("R4 read 0x1C", rq[0], 8'h03);
    chk("R4 read 0x1D", rq[1], 8'h02);
    chk("R4 read 0x1E", rq[2], 8'h5A);
    wq(2);
    chk("R4 released after nack", sda_oe, 1'b0);

    // R5 read-only status
    st_otemp = 1'b1; st_pgood = 1'b1;
    rd_run(8'h01, 1);
    chk("R5 status both", rq[0], 8'h81);
    wr_run(8'h01, 1, 8'h7E, 8'h00, 8'h00);
    st_otemp = 1'b0;
    rd_run(8'h01, 1);
    chk("R5 status after write", rq[0], 8'h01);

    // R6 sticky flags
    ev_pulse(1'b1, 1'b0, 1'b1);
    wq(2);
    chk("R6 flags set", flags, 3'b101);
    rd_run(8'h18, 1);
    chk("R6 read flags", rq[0], 8'h82);
    wr_run(8'h18, 1, 8'hFF, 8'h00, 8'h00);
    rd_run(8'h18, 1);
    chk("R6 write ones keeps", rq[0], 8'h82);
    wr_run(8'h18, 1, 8'h7F, 8'h00, 8'h00);
    rd_run(8'h18, 1);
    chk("R6 clear bit7", rq[0], 8'h02);
    ev_pulse(1'b0, 1'b1, 1'b0);
    rd_run(8'h18, 1);
    chk("R6 scp set", rq[0], 8'h12);
    wr_run(8'h18, 1, 8'h00, 8'h00, 8'h00);
    rd_run(8'h18, 1);
    chk("R6 all cleared", rq[0], 8'h00);

    // R7 reserved bits and unmapped indices
    wr_run(8'h12, 1, 8'hEF, 8'h00, 8'h00);
    chk("R7 dischg cleared", dischg_en, 1'b0);
    wr_run(8'h12, 2, 8'hFF, 8'hFF, 8'h00);
    rd_run(8'h12, 2);
    chk("R7 0x12 reserved", rq[0], 8'h10);
    chk("R7 0x13 unmapped", rq[1], 8'h00);
    wr_run(8'h40, 1, 8'hFF, 8'h00, 8'h00);
    rd_run(8'h40, 1);
    chk("R7 0x40 unmapped", rq[0], 8'h00);

    // R8 glitches on SDA (while SCL high) and SCL (while low) inside a data byte
    cmp_on = 1'b0;
    i_start;
    send_byte({ADR, 1'b0}, ack); chk("R8 address ack", ack, 1'b1);
    send_byte(8'h1E, ack);       chk("R8 index ack", ack, 1'b1);
    m_low = 1'b0; wq(Q);
    m_scl = 1'b1; wq(Q);
    m_low = 1'b1; wq(2); m_low = 1'b0;
    wq(Q - 2);
    m_scl = 1'b0; wq(Q);
    m_low = 1'b0; wq(5);
    m_scl = 1'b1; wq(2); m_scl = 1'b0;
    wq(Q - 7);
    m_scl = 1'b1; wq(2*Q); m_scl = 1'b0; wq(Q);
    for (int i = 5; i >= 0; i--) bit_cycle(i == 1 || i == 0, s);
    bit_cycle(1'b1, s);
    chk("R8 data ack after glitches", s, 1'b0);
    mwrite(8'h1E, 8'hC3);
    i_stop;
    cmp_on = 1'b1;
    wq(2);
    chk("R8 vlim written", vlim, 8'hC3);

    // R9 index kept across STOP
    cmp_on = 1'b0;
    i_start;
    send_byte({ADR, 1'b0}, ack);
    send_byte(8'h1D, ack); chk("R9 index ack", ack, 1'b1);
    i_stop;
    cmp_on = 1'b1;
    i_start;
    send_byte({ADR, 1'b1}, ack); chk("R9 read ack", ack, 1'b1);
    recv_byte(1'b0, rq[0]);
    recv_byte(1'b1, rq[1]);
    i_stop;
    chk("R9 first byte 0x1D", rq[0], 8'h02);
    chk("R9 second byte 0x1E", rq[1], 8'hC3);

    wq(10);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule